// File: doc/BRIEF.md
# Duration-Qualified Pattern Trigger

This block is the trigger unit of a two-channel digitizer. Each sample clock it receives one comparator bit per channel and, once armed, watches for the configured trigger condition. When the condition holds it emits a single-cycle trigger pulse and disarms. It stays deaf to further events until the arm strobe comes again. One sample clock is taken as one nanosecond, so all durations are counted in cycles.

The unit can fire at once on arming. It can also fire on a chosen edge of one channel, or on entering or leaving a per-channel high/low/don't-care pattern. The most selective mode measures how long the pattern stayed true and fires on the pattern's exit only if that length is above a limit, below a limit, or inside a window. Any of the event modes can be told to wait for the nth event. In the duration mode only the first of those events must pass the length test. A timeout can end the wait by firing on its own, and a flag marks that case.

Top module: `dqtrig_top`

## Requirements
- R1: While reset is held and in the cycle after it is released, `trig` and `trig_auto` are 0 and no trigger has been armed.
- R2: With `cfg_mode` = 0 (immediate), an arm strobe sampled on clock edge k produces `trig` high for the one cycle that follows edge k+1.
- R3: With `cfg_mode` = 1 (edge), the unit fires on the channel picked by `cfg_edge_ch` (0 = bit 0 of `cmp`, 1 = bit 1), on a rising edge when `cfg_edge_fall` = 0 and on a falling edge when it is 1. `trig` goes high in the cycle after the edge that sampled the changed bit, and a change on the other channel is ignored.
- R4: `cfg_pat` holds a 2-bit condition per channel: bits [1:0] apply to channel 0 and bits [3:2] to channel 1. The codes are 01 = must be low, 10 = must be high, and 00 or 11 = don't care. With `cfg_mode` = 2 the unit fires on entry into the pattern when `cfg_pat_exit` = 0 and on leaving it when `cfg_pat_exit` = 1.
- R5: With `cfg_mode` = 3 the unit fires on the pattern's exit only if L, the number of consecutive samples the pattern held, meets the test in `cfg_dur_op`. Code 0 requires L > `cfg_dur_lo`. Code 1 requires L < `cfg_dur_lo`. Code 2 requires `cfg_dur_lo` ≤ L ≤ `cfg_dur_hi`.
- R6: A pattern that held for fewer than 2 samples never qualifies and is never counted as an event in mode 3.
- R7: After a pattern exit whose length failed the test, a new pattern starting on the very next sample is measured from 1 and can qualify.
- R8: `cfg_nth` = n (0 treated as 1) makes the unit fire on the nth event counted since arming. In mode 3 the first counted event must pass the length test, while the later ones need only last at least 2 samples.
- R9: With `cfg_auto_en` = 1 and no trigger found, the unit fires by itself AUTO_CYCLES cycles after the arm edge, with `trig_auto` high alongside `trig`. Every other trigger has `trig_auto` = 0.
- R10: `trig` is one cycle wide. After firing the unit ignores all events and the timeout until it is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Arm strobe; restarts event count and timeout |
| cmp | input | 2 | Per-channel comparator bits for the current sample |
| cfg_mode | input | 2 | 0 immediate, 1 edge, 2 pattern, 3 duration-qualified |
| cfg_edge_ch | input | 1 | Channel used by edge mode |
| cfg_edge_fall | input | 1 | Edge polarity: 0 rising, 1 falling |
| cfg_pat | input | 4 | Per-channel pattern conditions |
| cfg_pat_exit | input | 1 | Pattern mode: 0 fire on entry, 1 on exit |
| cfg_dur_op | input | 2 | Length test: 0 greater, 1 less, 2 window |
| cfg_dur_lo | input | DW | Lower length limit in cycles |
| cfg_dur_hi | input | DW | Upper length limit in cycles |
| cfg_nth | input | CW | Event count to fire on |
| cfg_auto_en | input | 1 | Enables the self-trigger timeout |
| trig | output | 1 | One-cycle trigger pulse |
| trig_auto | output | 1 | Marks a trigger caused by the timeout |

## Verification
The assertions assume that the arm strobe never comes in the same cycle as a trigger that would otherwise fire, since arming takes priority and discards that event. They also assume the configuration inputs stay fixed while the unit is armed. The stimulus changes configuration only while the unit is idle, with the comparator inputs parked at a non-matching value. Comparator bits change only between clock edges, each value lasting whole cycles, so every measured length equals the number of cycles the bench held the pattern.

// File: rtl/dqtrig_pkg.sv
package dqtrig_pkg;

    localparam int NCH     = 2;
    localparam int MIN_LEN = 2;

    typedef enum logic [1:0] {
        TM_IMMED = 2'd0,
        TM_EDGE  = 2'd1,
        TM_PAT   = 2'd2,
        TM_QUAL  = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        DQ_GT    = 2'd0,
        DQ_LT    = 2'd1,
        DQ_RANGE = 2'd2
    } dur_op_e;

    localparam logic [1:0] PC_LOW  = 2'b01;
    localparam logic [1:0] PC_HIGH = 2'b10;

    typedef struct packed {
        logic edge_ev;
        logic enter_ev;
        logic exit_ev;
    } evt_s;

    function automatic logic cond_ok(input logic [1:0] cond, input logic bit_v);
        case (cond)
            PC_LOW:  return ~bit_v;
            PC_HIGH: return bit_v;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/dqtrig_match.sv
module dqtrig_match
    import dqtrig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   cmp,
    input  logic             edge_ch,
    input  logic             edge_fall,
    input  logic [2*NCH-1:0] pat,
    output evt_s             evt,
    output logic             match,
    output logic             match_q
);
    logic [NCH-1:0] cmp_q;
    logic [NCH-1:0] ch_ok;
    logic           cur_b;
    logic           old_b;

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            assign ch_ok[g] = cond_ok(pat[2*g +: 2], cmp[g]);
        end
    endgenerate

    assign match = &ch_ok;
    assign cur_b = cmp[edge_ch];
    assign old_b = cmp_q[edge_ch];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q   <= '0;
            match_q <= 1'b0;
        end else begin
            cmp_q   <= cmp;
            match_q <= match;
        end
    end

    always_comb begin
        evt.edge_ev  = edge_fall ? (old_b & ~cur_b) : (~old_b & cur_b);
        evt.enter_ev = match & ~match_q;
        evt.exit_ev  = ~match & match_q;
    end

endmodule

// File: rtl/dqtrig_dur.sv
module dqtrig_dur
    import dqtrig_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          match,
    input  logic          match_q,
    input  logic [1:0]    op,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    output logic          valid_exit,
    output logic          qual_exit
);
    localparam logic [DW-1:0] CNT_MAX = '1;
    localparam logic [DW-1:0] CNT_ONE = DW'(1);
    localparam logic [DW-1:0] LEN_MIN = DW'(MIN_LEN);

    logic [DW-1:0] dur_cnt;
    logic          crit;

    // Run length of the current pattern; restarts at 1 on entry.
    always_ff @(posedge clk) begin
        if (rst)                   dur_cnt <= '0;
        else if (!match)           dur_cnt <= '0;
        else if (!match_q)         dur_cnt <= CNT_ONE;
        else if (dur_cnt != CNT_MAX) dur_cnt <= dur_cnt + CNT_ONE;
    end

    always_comb begin
        case (dur_op_e'(op))
            DQ_GT:    crit = (dur_cnt > lo);
            DQ_LT:    crit = (dur_cnt < lo);
            DQ_RANGE: crit = (dur_cnt >= lo) && (dur_cnt <= hi);
            default:  crit = 1'b0;
        endcase
    end

    assign valid_exit = match_q && !match && (dur_cnt >= LEN_MIN);
    assign qual_exit  = valid_exit && crit;

    p_len_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (match && !match_q) |=> (dur_cnt == CNT_ONE));

endmodule

// File: rtl/dqtrig_seq.sv
module dqtrig_seq
    import dqtrig_pkg::*;
#(
    parameter int CW          = 20,
    parameter int AUTO_CYCLES = 50_000_000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic [1:0]    mode,
    input  logic          pat_exit,
    input  logic [CW-1:0] nth,
    input  logic          auto_en,
    input  evt_s          evt,
    input  logic          qual_exit,
    input  logic          valid_exit,
    output logic          trig,
    output logic          trig_auto
);
    localparam int            AW      = $clog2(AUTO_CYCLES + 1);
    localparam logic [AW-1:0] AUTO_LAST = AW'(AUTO_CYCLES - 1);
    localparam logic [AW-1:0] AUTO_ONE  = AW'(1);
    localparam logic [CW:0]   EV_ONE  = (CW+1)'(1);

    logic          armed;
    logic [CW-1:0] ev_cnt;
    logic [AW-1:0] auto_cnt;
    logic          hit;
    logic          first;
    logic [CW:0]   target;
    logic [CW:0]   nxt_cnt;
    logic          auto_hit;

    assign first    = (ev_cnt == '0);
    assign target   = (nth == '0) ? EV_ONE : {1'b0, nth};
    assign nxt_cnt  = {1'b0, ev_cnt} + EV_ONE;
    assign auto_hit = auto_en && (auto_cnt == AUTO_LAST);

    always_comb begin
        case (trig_mode_e'(mode))
            TM_IMMED: hit = 1'b1;
            TM_EDGE:  hit = evt.edge_ev;
            TM_PAT:   hit = pat_exit ? evt.exit_ev : evt.enter_ev;
            default:  hit = first ? qual_exit : valid_exit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            ev_cnt    <= '0;
            auto_cnt  <= '0;
            trig      <= 1'b0;
            trig_auto <= 1'b0;
        end else begin
            trig      <= 1'b0;
            trig_auto <= 1'b0;
            if (arm) begin
                armed    <= 1'b1;
                ev_cnt   <= '0;
                auto_cnt <= '0;
            end else if (armed) begin
                if (hit && (nxt_cnt >= target)) begin
                    armed <= 1'b0;
                    trig  <= 1'b1;
                end else if (auto_hit) begin
                    armed     <= 1'b0;
                    trig      <= 1'b1;
                    trig_auto <= 1'b1;
                end else begin
                    if (hit)
                        ev_cnt <= nxt_cnt[CW-1:0];
                    if (auto_cnt != AUTO_LAST)
                        auto_cnt <= auto_cnt + AUTO_ONE;
                end
            end
        end
    end

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);

    p_fire_disarms_r10: assert property (@(posedge clk) disable iff (rst)
        trig |-> !armed);

    p_fire_from_armed_r2: assert property (@(posedge clk) disable iff (rst)
        trig |-> $past(armed));

    p_auto_flag_r9: assert property (@(posedge clk) disable iff (rst)
        trig_auto |-> trig);

    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        armed |-> (nxt_cnt <= target));

endmodule

// File: rtl/dqtrig_top.sv
module dqtrig_top
    import dqtrig_pkg::*;
#(
    parameter int DW          = 8,
    parameter int CW          = 20,
    parameter int AUTO_CYCLES = 50_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [NCH-1:0]   cmp,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_edge_ch,
    input  logic             cfg_edge_fall,
    input  logic [2*NCH-1:0] cfg_pat,
    input  logic             cfg_pat_exit,
    input  logic [1:0]       cfg_dur_op,
    input  logic [DW-1:0]    cfg_dur_lo,
    input  logic [DW-1:0]    cfg_dur_hi,
    input  logic [CW-1:0]    cfg_nth,
    input  logic             cfg_auto_en,
    output logic             trig,
    output logic             trig_auto
);
    evt_s evt;
    logic match;
    logic match_q;
    logic valid_exit;
    logic qual_exit;

    dqtrig_match u_match (
        .clk       (clk),
        .rst       (rst),
        .cmp       (cmp),
        .edge_ch   (cfg_edge_ch),
        .edge_fall (cfg_edge_fall),
        .pat       (cfg_pat),
        .evt       (evt),
        .match     (match),
        .match_q   (match_q)
    );

    dqtrig_dur #(.DW(DW)) u_dur (
        .clk        (clk),
        .rst        (rst),
        .match      (match),
        .match_q    (match_q),
        .op         (cfg_dur_op),
        .lo         (cfg_dur_lo),
        .hi         (cfg_dur_hi),
        .valid_exit (valid_exit),
        .qual_exit  (qual_exit)
    );

    dqtrig_seq #(.CW(CW), .AUTO_CYCLES(AUTO_CYCLES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .mode       (cfg_mode),
        .pat_exit   (cfg_pat_exit),
        .nth        (cfg_nth),
        .auto_en    (cfg_auto_en),
        .evt        (evt),
        .qual_exit  (qual_exit),
        .valid_exit (valid_exit),
        .trig       (trig),
        .trig_auto  (trig_auto)
    );

endmodule

// File: tb/test_dqtrig_top.sv
module test_dqtrig_top;

    localparam int DW   = 8;
    localparam int CW   = 20;
    localparam int AUTO = 300;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arm = 1'b0;
    logic [1:0]    cmp = 2'b00;
    logic [1:0]    cfg_mode = 2'd0;
    logic          cfg_edge_ch = 1'b0;
    logic          cfg_edge_fall = 1'b0;
    logic [3:0]    cfg_pat = 4'b0000;
    logic          cfg_pat_exit = 1'b0;
    logic [1:0]    cfg_dur_op = 2'd0;
    logic [DW-1:0] cfg_dur_lo = '0;
    logic [DW-1:0] cfg_dur_hi = '0;
    logic [CW-1:0] cfg_nth = CW'(1);
    logic          cfg_auto_en = 1'b0;
    logic          trig;
    logic          trig_auto;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    typedef struct {
        int    at;
        bit    auto_f;
        string tag;
    } sb_item_t;

    sb_item_t sb[$];

    dqtrig_top #(.DW(DW), .CW(CW), .AUTO_CYCLES(AUTO)) i_dqtrig_top (
        .clk           (clk),
        .rst           (rst),
        .arm           (arm),
        .cmp           (cmp),
        .cfg_mode      (cfg_mode),
        .cfg_edge_ch   (cfg_edge_ch),
        .cfg_edge_fall (cfg_edge_fall),
        .cfg_pat       (cfg_pat),
        .cfg_pat_exit  (cfg_pat_exit),
        .cfg_dur_op    (cfg_dur_op),
        .cfg_dur_lo    (cfg_dur_lo),
        .cfg_dur_hi    (cfg_dur_hi),
        .cfg_nth       (cfg_nth),
        .cfg_auto_en   (cfg_auto_en),
        .trig          (trig),
        .trig_auto     (trig_auto)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares each trigger against the scoreboard.
    always @(negedge clk) begin
        if (!rst) begin
            if (trig) begin
                checks++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL %s: trigger at cycle %0d, expected none", cur_tag, cyc);
                end else begin
                    sb_item_t e;
                    e = sb.pop_front();
                    if (e.at != cyc || e.auto_f != trig_auto) begin
                        fails++;
                        $display("FAIL %s: trigger at cycle %0d auto=%0b, expected cycle %0d auto=%0b",
                                 e.tag, cyc, trig_auto, e.at, e.auto_f);
                    end
                end
            end else if (sb.size() > 0 && sb[0].at < cyc) begin
                sb_item_t e;
                e = sb.pop_front();
                checks++;
                fails++;
                $display("FAIL %s: no trigger by cycle %0d, expected at cycle %0d", e.tag, cyc, e.at);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL %s: watchdog expired, got hang, expected completion", cur_tag);
        finish_run();
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(input int at, input bit a, input string tag);
        sb_item_t e;
        e.at = at;
        e.auto_f = a;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic arm_now();
        arm = 1'b1;
        step(1);
        arm = 1'b0;
    endtask

    task automatic settle(input int n);
        step(n);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d triggers outstanding, expected 0", cur_tag, sb.size());
            sb.delete();
        end
    endtask

    // Holds the qualifying pattern (ch0 high) for L samples, then leaves it.
    task automatic hold_pat(input int len, input bit fire, input string tag);
        cmp = 2'b01;
        step(len);
        if (fire) expect_at(cyc + 1, 1'b0, tag);
        cmp = 2'b00;
        step(3);
    endtask

    task automatic qual_try(input logic [1:0] op, input int lo, input int hi,
                            input int len, input bit fire, input string tag);
        cur_tag = tag;
        cfg_mode = 2'd3;
        cfg_pat = 4'b0010;
        cfg_nth = CW'(1);
        cfg_dur_op = op;
        cfg_dur_lo = DW'(lo);
        cfg_dur_hi = DW'(hi);
        cmp = 2'b00;
        step(2);
        arm_now();
        step(2);
        hold_pat(len, fire, tag);
        settle(4);
    endtask

    initial begin
        int c;
        step(3);
        rst = 1'b0;
        step(1);
        // R1: reset state
        checks++;
        if (trig !== 1'b0 || trig_auto !== 1'b0) begin
            fails++;
            $display("FAIL R1: trig=%0b trig_auto=%0b, expected 0 0", trig, trig_auto);
        end
        step(5);
        settle(1);

        // R2: immediate mode
        cur_tag = "R2";
        cfg_mode = 2'd0;
        expect_at(cyc + 2, 1'b0, "R2");
        arm_now();
        settle(6);

        // R3: rising edge on channel 1, channel 0 ignored
        cur_tag = "R3";
        cfg_mode = 2'd1;
        cfg_edge_ch = 1'b1;
        cfg_edge_fall = 1'b0;
        cmp = 2'b00;
        step(2);
        arm_now();
        step(2);
        cmp = 2'b01;
        step(3);
        expect_at(cyc + 1, 1'b0, "R3");
        cmp = 2'b11;
        step(3);
        // R10: later edges ignored until re-armed
        cur_tag = "R10";
        cmp = 2'b00;
        step(2);
        cmp = 2'b11;
        step(4);
        settle(2);

        // R3: falling edge on channel 0, channel 1 fall ignored
        cur_tag = "R3";
        cfg_edge_ch = 1'b0;
        cfg_edge_fall = 1'b1;
        step(2);
        arm_now();
        step(2);
        cmp = 2'b01;
        step(3);
        expect_at(cyc + 1, 1'b0, "R3");
        cmp = 2'b00;
        settle(4);

        // R4: pattern entry, ch0 high and ch1 low
        cur_tag = "R4";
        cfg_mode = 2'd2;
        cfg_pat = 4'b0110;
        cfg_pat_exit = 1'b0;
        cmp = 2'b00;
        step(2);
        arm_now();
        step(2);
        cmp = 2'b10;
        step(2);
        expect_at(cyc + 1, 1'b0, "R4");
        cmp = 2'b01;
        settle(4);

        // R4: pattern exit
        cfg_pat_exit = 1'b1;
        step(1);
        arm_now();
        step(2);
        expect_at(cyc + 1, 1'b0, "R4");
        cmp = 2'b11;
        settle(4);

        // R4: channel 1 don't care
        cfg_pat = 4'b0010;
        cfg_pat_exit = 1'b0;
        cmp = 2'b00;
        step(2);
        arm_now();
        step(2);
        cmp = 2'b10;
        step(2);
        expect_at(cyc + 1, 1'b0, "R4");
        cmp = 2'b11;
        settle(4);
        cmp = 2'b00;

        // R5: greater-than, less-than, window with edges of each limit
        qual_try(2'd0, 20, 0, 20, 1'b0, "R5");
        qual_try(2'd0, 20, 0, 21, 1'b1, "R5");
        qual_try(2'd1, 20, 0, 25, 1'b0, "R5");
        qual_try(2'd1, 20, 0, 19, 1'b1, "R5");
        qual_try(2'd2, 20, 160, 19, 1'b0, "R5");
        qual_try(2'd2, 20, 160, 20, 1'b1, "R5");
        qual_try(2'd2, 20, 160, 160, 1'b1, "R5");
        qual_try(2'd2, 20, 160, 161, 1'b0, "R5");

        // R6: one-sample excursion rejected, two samples accepted
        qual_try(2'd1, 20, 0, 1, 1'b0, "R6");
        qual_try(2'd1, 20, 0, 2, 1'b1, "R6");

        // R7: invalid pattern followed at once by a valid one
        cur_tag = "R7";
        cfg_dur_op = 2'd2;
        cfg_dur_lo = DW'(20);
        cfg_dur_hi = DW'(30);
        cmp = 2'b00;
        step(2);
        arm_now();
        step(2);
        cmp = 2'b01;
        step(40);
        cmp = 2'b00;
        step(1);
        cmp = 2'b01;
        step(25);
        expect_at(cyc + 1, 1'b0, "R7");
        cmp = 2'b00;
        settle(4);

        // R8: third event, only the first length-qualified; noise not counted
        cur_tag = "R8";
        cfg_dur_op = 2'd0;
        cfg_dur_lo = DW'(20);
        cfg_nth = CW'(3);
        step(2);
        arm_now();
        step(2);
        hold_pat(10, 1'b0, "R8");
        hold_pat(25, 1'b0, "R8");
        hold_pat(1, 1'b0, "R8");
        hold_pat(5, 1'b0, "R8");
        hold_pat(3, 1'b1, "R8");
        settle(4);

        // R8: second rising edge in edge mode
        cfg_mode = 2'd1;
        cfg_edge_ch = 1'b0;
        cfg_edge_fall = 1'b0;
        cfg_nth = CW'(2);
        cmp = 2'b00;
        step(2);
        arm_now();
        step(2);
        cmp = 2'b01;
        step(2);
        cmp = 2'b00;
        step(2);
        expect_at(cyc + 1, 1'b0, "R8");
        cmp = 2'b01;
        settle(4);
        cmp = 2'b00;
        cfg_nth = CW'(1);

        // R9: timeout fires with the flag set
        cur_tag = "R9";
        cfg_edge_ch = 1'b1;
        cfg_auto_en = 1'b1;
        step(2);
        c = cyc;
        expect_at(c + 1 + AUTO, 1'b1, "R9");
        arm_now();
        step(AUTO + 20);
        settle(2);
        // R10: no second timeout without re-arming
        cur_tag = "R10";
        step(2 * AUTO);
        settle(2);

        // R9: a real event before the timeout fires without the flag
        cur_tag = "R9";
        arm_now();
        step(10);
        expect_at(cyc + 1, 1'b0, "R9");
        cmp = 2'b10;
        step(3);
        cmp = 2'b00;
        step(AUTO + 20);
        settle(2);
        cfg_auto_en = 1'b0;

        finish_run();
    end

endmodule